// File: doc/BRIEF.md
# Descending Memory Stack Controller

This block runs a last-in-first-out stack that lives in an external byte-addressed memory of 32-bit words. It serves both as a data stack and as the place where subroutine return addresses are saved as calls nest and restored as returns execute. The block owns a stack pointer that always holds the byte address of the word on top. It turns push and pop strobes into accesses on a simple synchronous memory port. That port presents an address, write data and a write enable in the cycle of the request, and it returns read data after the next clock edge.

The stack grows toward lower addresses, one word (4 bytes) per push. A push lowers the pointer by 4 and writes the word at the lowered address. A pop reads the word at the pointer and then raises the pointer by 4. Two parameters fix the stack region: the deepest address that may hold a word, and the address of the first word pushed. If a request cannot be served, the block refuses it and reports the reason with a one-cycle pulse.

Top module: `stack_ctl`

## Requirements
- R1: After reset the pointer equals the bottom address plus 4, `empty_o` is 1, `full_o` is 0, and `pop_valid_o`, `overflow_o`, `underflow_o` and `conflict_o` are all 0.
- R2: A lone push while not full drives `mem_we_o`=1, `mem_addr_o`=pointer−4 and `mem_wdata_o`=`push_data_i` in the same cycle. The pointer is 4 lower in the following cycle.
- R3: A lone push while `full_o` is 1 does not write memory and leaves the pointer unchanged. `overflow_o` pulses high for the one cycle after the request.
- R4: A lone pop while not empty drives `mem_addr_o`=pointer with `mem_we_o`=0. In the following cycle, `pop_valid_o` is 1, `pop_data_o` carries the word at that address, and the pointer is 4 higher.
- R5: A lone pop while `empty_o` is 1 produces no `pop_valid_o` and leaves the pointer unchanged. `underflow_o` pulses high for the one cycle after the request.
- R6: A push and a pop in the same cycle do not write memory, produce no `pop_valid_o` and leave the pointer unchanged. `conflict_o` pulses high for the one cycle after the request.
- R7: Words come out of pops in the reverse order of the pushes that stored them, including when pushes and pops interleave.
- R8: The two low bits of the pointer are always 0, and the pointer stays between the limit address and the bottom address plus 4, inclusive.
- R9: `full_o` is 1 exactly when the pointer equals the limit address. `empty_o` is 1 exactly when the pointer equals the bottom address plus 4. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request strobe |
| push_data_i | input | DW | Word to push |
| pop_i | input | 1 | Pop request strobe |
| pop_data_o | output | DW | Popped word, meaningful while pop_valid_o is 1 |
| pop_valid_o | output | 1 | One-cycle pulse marking pop_data_o |
| full_o | output | 1 | No room for another word |
| empty_o | output | 1 | No word on the stack |
| overflow_o | output | 1 | Pulse: a push was refused because the stack was full |
| underflow_o | output | 1 | Pulse: a pop was refused because the stack was empty |
| conflict_o | output | 1 | Pulse: push and pop arrived together and were both refused |
| sp_o | output | AW | Current stack pointer |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | DW | Memory read data, valid the cycle after the address |

## Verification
The memory request (address, write enable and write data) belongs to the same cycle as the strobe. The bench drives the strobe on a falling edge and samples the memory port 1 ns later, before the rising edge. Everything else is due one rising edge after the request: the pointer step, the pop data with its valid pulse, the error pulses and the new full and empty levels. The bench samples these on the next falling edge, compares them with a reference model that it updates at that point, and then drives the next request. A behavioural memory in the bench stores writes on the rising edge and registers read data on that same edge, so popped data is compared in the cycle after the pop.

// File: rtl/stack_ctl.sv
module stack_ctl #(
  parameter int             AW     = 16,
  parameter int             DW     = 32,
  parameter logic [AW-1:0]  BOTTOM = 16'h0100,
  parameter logic [AW-1:0]  LIMIT  = 16'h00E0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic          conflict_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [AW-1:0] STEP     = AW'(4);
  localparam logic [AW-1:0] EMPTY_SP = BOTTOM + STEP;

  logic [AW-1:0] sp;
  logic both, do_push, do_pop;

  assign both    = push_i & pop_i;
  assign full_o  = (sp == LIMIT);
  assign empty_o = (sp == EMPTY_SP);
  assign do_push = push_i & ~pop_i & ~full_o;
  assign do_pop  = pop_i & ~push_i & ~empty_o;

  assign sp_o        = sp;
  assign mem_we_o    = do_push;
  assign mem_addr_o  = do_push ? sp - STEP : sp;
  assign mem_wdata_o = push_data_i;
  assign pop_data_o  = mem_rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp          <= EMPTY_SP;
      pop_valid_o <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      conflict_o  <= 1'b0;
    end else begin
      if (do_push)     sp <= sp - STEP;
      else if (do_pop) sp <= sp + STEP;
      pop_valid_o <= do_pop;
      overflow_o  <= push_i & ~pop_i & full_o;
      underflow_o <= pop_i & ~push_i & empty_o;
      conflict_o  <= both;
    end
  end

  // R8: pointer alignment and range
  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[1:0] == 2'b00);
  p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_o >= LIMIT) && (sp_o <= EMPTY_SP));

  // R2: push lowers pointer by one word
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) - STEP) && !overflow_o);

  // R3: refused push
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> overflow_o && $stable(sp_o));
  p_full_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !(mem_we_o && mem_addr_o < LIMIT));

  // R4: pop returns data next cycle and raises pointer
  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> pop_valid_o && (sp_o == $past(sp_o) + STEP));

  // R5: refused pop
  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> underflow_o && !pop_valid_o && $stable(sp_o));

  // R6: simultaneous requests
  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> conflict_o && !pop_valid_o && $stable(sp_o));
  p_conflict_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |-> !mem_we_o);

  // R9: status flags exclusive
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
endmodule

// File: tb/sim_stack_ctl.sv
`timescale 1ns/1ps
module sim_stack_ctl;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] BOTTOM = 16'h0100;
  localparam logic [AW-1:0] LIMIT  = 16'h00E0;
  localparam logic [AW-1:0] EMPTY_SP = BOTTOM + 16'd4;

  logic clk = 0, rst_n = 0;
  logic push_i = 0, pop_i = 0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o, mem_wdata_o, mem_rdata_i;
  logic pop_valid_o, full_o, empty_o, overflow_o, underflow_o, conflict_o, mem_we_o;
  logic [AW-1:0] sp_o, mem_addr_o;

  logic [DW-1:0] mem [128];
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[8:2]] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o[8:2]];
  end

  stack_ctl #(.AW(AW), .DW(DW), .BOTTOM(BOTTOM), .LIMIT(LIMIT)) u0 (
    .clk, .rst_n, .push_i, .push_data_i, .pop_i, .pop_data_o, .pop_valid_o,
    .full_o, .empty_o, .overflow_o, .underflow_o, .conflict_o, .sp_o,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_rdata_i);

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_sp;
  logic [DW-1:0] q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_full(input logic [AW-1:0] s);
    return s == LIMIT;
  endfunction

  task automatic step(input bit pu, input bit po, input logic [DW-1:0] d);
    bit lone_push, lone_pop, wr, rd;
    logic [DW-1:0] exp_d;
    lone_push = pu && !po;
    lone_pop  = po && !pu;
    wr = lone_push && !model_full(m_sp);
    rd = lone_pop && (m_sp != EMPTY_SP);
    push_i = pu; pop_i = po; push_data_i = d;
    #1;
    if (wr) begin
      chk(mem_we_o == 1'b1, "R2 write enable", mem_we_o, 1);
      chk(mem_addr_o == m_sp - 16'd4, "R2 write address", mem_addr_o, m_sp - 16'd4);
      chk(mem_wdata_o == d, "R2 write data", mem_wdata_o, d);
    end else if (rd) begin
      chk(mem_we_o == 1'b0 && mem_addr_o == m_sp, "R4 read address", {mem_we_o, 15'd0, mem_addr_o}, {16'd0, m_sp});
    end else if (pu && po) begin
      chk(mem_we_o == 1'b0, "R6 no write on conflict", mem_we_o, 0);
    end else if (lone_push) begin
      chk(mem_we_o == 1'b0, "R3 no write when full", mem_we_o, 0);
    end
    @(negedge clk);
    push_i = 0; pop_i = 0;
    if (wr) begin m_sp = m_sp - 16'd4; q.push_back(d); end
    if (rd) begin m_sp = m_sp + 16'd4; exp_d = q.pop_back(); end
    chk(sp_o == m_sp, "R8 pointer value", sp_o, m_sp);
    chk(sp_o[1:0] == 2'b00, "R8 alignment", sp_o, sp_o & 16'hFFFC);
    chk(pop_valid_o == rd, "R4 pop valid", pop_valid_o, rd);
    if (rd) chk(pop_data_o == exp_d, "R7 LIFO data", pop_data_o, exp_d);
    chk(overflow_o == (lone_push && !wr), "R3 overflow pulse", overflow_o, lone_push && !wr);
    chk(underflow_o == (lone_pop && !rd), "R5 underflow pulse", underflow_o, lone_pop && !rd);
    chk(conflict_o == (pu && po), "R6 conflict pulse", conflict_o, pu && po);
    chk(full_o == (m_sp == LIMIT), "R9 full flag", full_o, m_sp == LIMIT);
    chk(empty_o == (m_sp == EMPTY_SP), "R9 empty flag", empty_o, m_sp == EMPTY_SP);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_sp = EMPTY_SP;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sp_o == EMPTY_SP, "R1 reset pointer", sp_o, EMPTY_SP);
    chk(empty_o && !full_o, "R1 reset flags", {full_o, empty_o}, 2'b01);
    chk(!pop_valid_o && !overflow_o && !underflow_o && !conflict_o, "R1 reset pulses",
        {pop_valid_o, overflow_o, underflow_o, conflict_o}, 0);

    step(0, 1, 0);                               // R5 pop on empty
    step(1, 1, 32'hDEAD0000);                    // R6 conflict while empty
    for (int i = 0; i < 10; i++) step(1, 0, 32'hA0000000 + i); // R2 fill, R3 on the tenth
    chk(full_o, "R3 full after nine pushes", full_o, 1);
    step(1, 0, 32'hBAD0BAD0);                    // R3 again
    step(1, 1, 32'h12345678);                    // R6 conflict while full
    for (int i = 0; i < 10; i++) step(0, 1, 0);  // R4/R7 drain, R5 on last
    step(1, 0, 32'h11111111);                    // R7 interleaved
    step(1, 0, 32'h22222222);
    step(0, 1, 0);
    step(1, 0, 32'h33333333);
    step(0, 1, 0);
    step(0, 1, 0);

    for (int i = 0; i < 800; i++) begin
      int r;
      r = $urandom % 8;
      if (r < 3)      step(1, 0, $urandom);
      else if (r < 6) step(0, 1, 0);
      else if (r == 6) step(1, 1, $urandom);
      else            step(0, 0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule